// File: doc/BRIEF.md
# Vital-Only Level-0 Data Cache

This block is a small, single-ported level-0 data cache that sits in front of a slower, multi-cycle first-level data cache. Each load arrives tagged with a vitality bit, which says whether the load's consumer needs the data at once. Only vital loads look up this cache. Only a vital load that misses brings a line into it. Non-vital loads are always sent to the slower cache, and they never place data here. The small capacity is therefore kept for the data that actually limits performance.

Several load requesters compete for the single port in each cycle. Each requester presents an address, a vitality bit and an age (sequence) number. A pending store takes the port ahead of every load. Otherwise a vital load always wins over a non-vital one, and within one class the oldest request wins. A requester that loses keeps its request raised and competes again in the next cycle.

The cache is direct-mapped. Stores are written through to the lower level on every cycle they occur, and they update a line here only when that line is resident. Responses from the lower level come back on their own channel. When such a response belongs to a vital miss, it fills the line in the same cycle that it answers the requester.

Top module: `vl0_cache`

## Requirements
- R1: After reset, no line is resident and `hit_valid`, `lo_rd_valid`, `miss_valid` and every bit of `req_grant` are 0.
- R2: At most one bit of `req_grant` is set in any cycle, and only for a requester with `req_valid` set. No load is granted in a cycle when `st_valid` is 1.
- R3: When any valid request has its vital bit set, the grant goes to a vital request.
- R4: Within one vitality class, the request with the lowest `req_seq` is granted, and equal sequence numbers go to the lowest requester index. A requester that is not granted and keeps `req_valid` high is granted in a later cycle once the others drop.
- R5: When a granted vital load hits, `hit_valid` is 1 in the next cycle with `hit_id` set to the requester index and `hit_data` set to the stored word. In the grant cycle `lo_rd_valid` stays 0.
- R6: When a granted vital load misses, it is forwarded in the same cycle on `lo_rd_valid`/`lo_rd_addr`/`lo_rd_id` with `lo_rd_alloc`=1. A lower response carrying alloc=1 appears in the same cycle on `miss_valid`/`miss_id`/`miss_data` and fills the line, so a vital load to that line issued in the next cycle hits.
- R7: A granted non-vital load is always forwarded with `lo_rd_alloc`=0, even when its line is resident. It never produces `hit_valid`, and its response neither fills a line nor evicts one.
- R8: A store appears on `lo_wr_valid`/`lo_wr_addr`/`lo_wr_data` in the same cycle. If its line is resident, the stored word is replaced. If its line is not resident, no line is allocated and the resident line is kept.
- R9: The line index is address bits [7:5] and the tag is bits [15:8]. A vital miss to the same index with a different tag replaces the resident line.
- R10: The word returned for a load is word number addr[4:2] of its 32-byte line, where word k is line bits [32k+31:32k]. `lo_rsp_addr` is the word address (byte address bits [15:2]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_REQ | Load request pending, one bit per requester |
| req_vital | input | NUM_REQ | Vitality bit of each request |
| req_seq | input | NUM_REQ*SEQ_W | Age of each request; lower is older |
| req_addr | input | NUM_REQ*ADDR_W | Byte address of each request |
| req_grant | output | NUM_REQ | Requester that owns the port this cycle |
| st_valid | input | 1 | Store present |
| st_addr | input | ADDR_W | Store byte address, word aligned |
| st_data | input | 32 | Store word |
| hit_valid | output | 1 | Hit response valid |
| hit_id | output | ID_W | Requester of the hit |
| hit_data | output | 32 | Hit word |
| lo_rd_valid | output | 1 | Read forwarded to the lower level |
| lo_rd_addr | output | ADDR_W | Forwarded byte address |
| lo_rd_id | output | ID_W | Forwarded requester index |
| lo_rd_alloc | output | 1 | The forwarded read should fill this cache |
| lo_rsp_valid | input | 1 | Lower response valid |
| lo_rsp_addr | input | ADDR_W-2 | Response word address |
| lo_rsp_id | input | ID_W | Response requester index |
| lo_rsp_alloc | input | 1 | Response fills this cache |
| lo_rsp_line | input | 256 | Whole line from below |
| miss_valid | output | 1 | Forwarded-load response valid |
| miss_id | output | ID_W | Requester of that response |
| miss_data | output | 32 | Requested word |
| lo_wr_valid | output | 1 | Write-through valid |
| lo_wr_addr | output | ADDR_W | Write-through address |
| lo_wr_data | output | 32 | Write-through word |

## Verification
The grant, the forwarded read and the write-through all follow their inputs in the same cycle. The bench drives at the falling edge and checks these outputs a moment later, in the same low phase. A hit response is due exactly one rising edge after the grant. A miss response is due in the cycle the lower model returns it, three edges after the forward. The fill is visible to a load issued in the cycle after that. Each check therefore samples at the falling edge that follows the counted number of rising edges. Arbitration is swept over every valid and vital pattern of four requesters, with three age patterns that include ties. Every line index and every word offset goes through a miss followed by hits.

// File: rtl/vl0_pkg.sv
`timescale 1ns/1ps
package vl0_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_HIT  = 2'd1,
        RT_FWD  = 2'd2
    } route_e;
endpackage

// File: rtl/vl0_arb.sv
`timescale 1ns/1ps
module vl0_arb #(
    parameter int NUM_REQ = 4,
    parameter int SEQ_W   = 4,
    parameter int ID_W    = 2
) (
    input  logic [NUM_REQ-1:0]       valid,
    input  logic [NUM_REQ-1:0]       vital,
    input  logic [NUM_REQ*SEQ_W-1:0] seq,
    input  logic                     block,
    output logic [NUM_REQ-1:0]       grant,
    output logic [ID_W-1:0]          win_idx,
    output logic                     win_any,
    output logic                     win_vital
);
    localparam int KEY_W = SEQ_W + 1;

    logic [KEY_W-1:0] best_key;
    logic [KEY_W-1:0] cand_key;

    always_comb begin
        win_any   = 1'b0;
        win_idx   = '0;
        best_key  = '0;
        cand_key  = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            cand_key = {~vital[i], seq[i*SEQ_W +: SEQ_W]};
            if (valid[i] && !block && (!win_any || cand_key < best_key)) begin
                win_any  = 1'b1;
                win_idx  = ID_W'(i);
                best_key = cand_key;
            end
        end
        grant          = '0;
        grant[win_idx] = win_any;
        win_vital      = win_any && !best_key[KEY_W-1];
    end
endmodule

// File: rtl/vl0_store.sv
`timescale 1ns/1ps
module vl0_store #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3,
    parameter int TAG_W     = 8,
    parameter int LINE_W    = 256,
    parameter int WORD_W    = 32,
    parameter int WSEL_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  logic [WORD_W-1:0] wr_data
);
    typedef struct packed {
        logic [NUM_LINES-1:0]             vld;
        logic [NUM_LINES-1:0][TAG_W-1:0]  tag;
        logic [NUM_LINES-1:0][LINE_W-1:0] data;
    } store_t;

    store_t st_q, st_d;

    always_comb begin
        rd_vld  = st_q.vld[rd_idx];
        rd_tag  = st_q.tag[rd_idx];
        rd_line = st_q.data[rd_idx];

        st_d = st_q;
        if (fill_en) begin
            st_d.vld[fill_idx]  = 1'b1;
            st_d.tag[fill_idx]  = fill_tag;
            st_d.data[fill_idx] = fill_line;
        end
        // a store landing with a fill of the same line is merged on top of it
        if (wr_en && st_d.vld[wr_idx] && st_d.tag[wr_idx] == wr_tag) begin
            st_d.data[wr_idx][int'(wr_wsel)*WORD_W +: WORD_W] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/vl0_cache.sv
`timescale 1ns/1ps
module vl0_cache
    import vl0_pkg::*;
#(
    parameter int NUM_REQ    = 4,
    parameter int SEQ_W      = 4,
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 8,
    localparam int ID_W      = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [NUM_REQ-1:0]        req_vital,
    input  logic [NUM_REQ*SEQ_W-1:0]  req_seq,
    input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
    output logic [NUM_REQ-1:0]        req_grant,
    input  logic                      st_valid,
    input  logic [ADDR_W-1:0]         st_addr,
    input  logic [31:0]               st_data,
    output logic                      hit_valid,
    output logic [ID_W-1:0]           hit_id,
    output logic [31:0]               hit_data,
    output logic                      lo_rd_valid,
    output logic [ADDR_W-1:0]         lo_rd_addr,
    output logic [ID_W-1:0]           lo_rd_id,
    output logic                      lo_rd_alloc,
    input  logic                      lo_rsp_valid,
    input  logic [ADDR_W-3:0]         lo_rsp_addr,
    input  logic [ID_W-1:0]           lo_rsp_id,
    input  logic                      lo_rsp_alloc,
    input  logic [LINE_W-1:0]         lo_rsp_line,
    output logic                      miss_valid,
    output logic [ID_W-1:0]           miss_id,
    output logic [31:0]               miss_data,
    output logic                      lo_wr_valid,
    output logic [ADDR_W-1:0]         lo_wr_addr,
    output logic [31:0]               lo_wr_data
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int WPL    = LINE_BYTES / (WORD_W / 8);
    localparam int WSEL_W = $clog2(WPL);

    typedef struct packed {
        logic              hit_valid;
        logic [ID_W-1:0]   hit_id;
        logic [WORD_W-1:0] hit_data;
    } rsp_t;

    rsp_t r_q, r_d;

    logic [ID_W-1:0]   win;
    logic              win_any;
    logic              win_vital;
    logic [ADDR_W-1:0] ld_addr;
    logic [IDX_W-1:0]  ld_idx;
    logic [TAG_W-1:0]  ld_tag;
    logic [WSEL_W-1:0] ld_wsel;
    logic              rd_vld;
    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_line;
    route_e            route;
    logic [WSEL_W-1:0] rsp_wsel;

    vl0_arb #(
        .NUM_REQ (NUM_REQ),
        .SEQ_W   (SEQ_W),
        .ID_W    (ID_W)
    ) arb_i (
        .valid     (req_valid),
        .vital     (req_vital),
        .seq       (req_seq),
        .block     (st_valid),
        .grant     (req_grant),
        .win_idx   (win),
        .win_any   (win_any),
        .win_vital (win_vital)
    );

    always_comb begin
        ld_addr = req_addr[int'(win)*ADDR_W +: ADDR_W];
        ld_idx  = ld_addr[OFF_W +: IDX_W];
        ld_tag  = ld_addr[ADDR_W-1 -: TAG_W];
        ld_wsel = ld_addr[2 +: WSEL_W];
    end

    vl0_store #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W),
        .LINE_W    (LINE_W),
        .WORD_W    (WORD_W),
        .WSEL_W    (WSEL_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (ld_idx),
        .rd_vld    (rd_vld),
        .rd_tag    (rd_tag),
        .rd_line   (rd_line),
        .fill_en   (lo_rsp_valid && lo_rsp_alloc),
        .fill_idx  (lo_rsp_addr[OFF_W-2 +: IDX_W]),
        .fill_tag  (lo_rsp_addr[ADDR_W-3 -: TAG_W]),
        .fill_line (lo_rsp_line),
        .wr_en     (st_valid),
        .wr_idx    (st_addr[OFF_W +: IDX_W]),
        .wr_tag    (st_addr[ADDR_W-1 -: TAG_W]),
        .wr_wsel   (st_addr[2 +: WSEL_W]),
        .wr_data   (st_data)
    );

    always_comb begin
        if (!win_any) begin
            route = RT_NONE;
        end else if (win_vital && rd_vld && rd_tag == ld_tag) begin
            route = RT_HIT;
        end else begin
            route = RT_FWD;
        end

        r_d           = r_q;
        r_d.hit_valid = (route == RT_HIT);
        r_d.hit_id    = win;
        r_d.hit_data  = rd_line[int'(ld_wsel)*WORD_W +: WORD_W];

        lo_rd_valid = (route == RT_FWD);
        lo_rd_addr  = ld_addr;
        lo_rd_id    = win;
        lo_rd_alloc = win_vital;

        rsp_wsel   = lo_rsp_addr[0 +: WSEL_W];
        miss_valid = lo_rsp_valid;
        miss_id    = lo_rsp_id;
        miss_data  = lo_rsp_line[int'(rsp_wsel)*WORD_W +: WORD_W];

        lo_wr_valid = st_valid;
        lo_wr_addr  = st_addr;
        lo_wr_data  = st_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hit_valid = r_q.hit_valid;
    assign hit_id    = r_q.hit_id;
    assign hit_data  = r_q.hit_data;
endmodule

// File: rtl/vl0_cache_chk.sv
`timescale 1ns/1ps
module vl0_cache_chk #(
    parameter int NUM_REQ = 4,
    parameter int ADDR_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] req_valid,
    input logic [NUM_REQ-1:0] req_vital,
    input logic [NUM_REQ-1:0] req_grant,
    input logic               st_valid,
    input logic [ADDR_W-1:0]  st_addr,
    input logic               lo_wr_valid,
    input logic [ADDR_W-1:0]  lo_wr_addr,
    input logic               hit_valid,
    input logic               lo_rd_valid,
    input logic               lo_rd_alloc
);
    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant) && ((req_grant & ~req_valid) == '0));

    assert_store_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (req_grant == '0));

    assert_vital_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_valid & req_vital) != '0 && req_grant != '0) |-> ((req_grant & req_vital) != '0));

    assert_hit_follows_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> ($past((req_grant & req_vital) != '0) && !$past(lo_rd_valid)));

    assert_alloc_matches_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd_valid |-> (lo_rd_alloc == ((req_grant & req_vital) != '0)));

    assert_write_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (lo_wr_valid && lo_wr_addr == st_addr));
endmodule

bind vl0_cache vl0_cache_chk #(
    .NUM_REQ (NUM_REQ),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_vital   (req_vital),
    .req_grant   (req_grant),
    .st_valid    (st_valid),
    .st_addr     (st_addr),
    .lo_wr_valid (lo_wr_valid),
    .lo_wr_addr  (lo_wr_addr),
    .hit_valid   (hit_valid),
    .lo_rd_valid (lo_rd_valid),
    .lo_rd_alloc (lo_rd_alloc)
);

// File: tb/vl0_cache_tb.sv
`timescale 1ns/1ps
module vl0_cache_tb_top;
    localparam int N  = 4;
    localparam int SW = 4;
    localparam int AW = 16;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]    req_valid = '0;
    logic [N-1:0]    req_vital = '0;
    logic [N*SW-1:0] req_seq = '0;
    logic [N*AW-1:0] req_addr = '0;
    logic [N-1:0]    req_grant;
    logic            st_valid = 1'b0;
    logic [AW-1:0]   st_addr = '0;
    logic [31:0]     st_data = '0;
    logic            hit_valid;
    logic [IW-1:0]   hit_id;
    logic [31:0]     hit_data;
    logic            lo_rd_valid;
    logic [AW-1:0]   lo_rd_addr;
    logic [IW-1:0]   lo_rd_id;
    logic            lo_rd_alloc;
    logic            lo_rsp_valid;
    logic [AW-3:0]   lo_rsp_addr;
    logic [IW-1:0]   lo_rsp_id;
    logic            lo_rsp_alloc;
    logic [255:0]    lo_rsp_line;
    logic            miss_valid;
    logic [IW-1:0]   miss_id;
    logic [31:0]     miss_data;
    logic            lo_wr_valid;
    logic [AW-1:0]   lo_wr_addr;
    logic [31:0]     lo_wr_data;

    vl0_cache dut_i (.*);

    // lower-level model: 1024-word memory, 3-cycle read pipe
    logic [31:0]   mem [0:1023];
    logic          p_v [0:2];
    logic [AW-1:0] p_a [0:2];
    logic [IW-1:0] p_i [0:2];
    logic          p_l [0:2];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) p_v[k] <= 1'b0;
        end else begin
            p_v[0] <= lo_rd_valid; p_a[0] <= lo_rd_addr; p_i[0] <= lo_rd_id; p_l[0] <= lo_rd_alloc;
            for (int k = 1; k < 3; k++) begin
                p_v[k] <= p_v[k-1]; p_a[k] <= p_a[k-1]; p_i[k] <= p_i[k-1]; p_l[k] <= p_l[k-1];
            end
        end
    end

    always_comb begin
        lo_rsp_valid = p_v[2];
        lo_rsp_addr  = p_a[2][AW-1:2];
        lo_rsp_id    = p_i[2];
        lo_rsp_alloc = p_l[2];
        for (int k = 0; k < 8; k++)
            lo_rsp_line[k*32 +: 32] = mem[{p_a[2][11:5], 3'(k)}];
    end

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [AW-1:0] a);
        return mem[a[11:2]];
    endfunction

    task automatic set_req(input int id, input logic [AW-1:0] a, input bit vt, input int sq);
        req_valid[id] = 1'b1;
        req_vital[id] = vt;
        req_addr[id*AW +: AW] = a;
        req_seq[id*SW +: SW] = SW'(sq);
    endtask

    // starts and ends at a falling edge
    task automatic load_hit(input int id, input logic [AW-1:0] a, input string tag);
        logic [31:0] e;
        e = word_of(a);
        set_req(id, a, 1'b1, 0);
        #1;
        chk(req_grant == N'(1 << id), {tag, " grant"}, req_grant, 1 << id);
        chk(lo_rd_valid == 1'b0, {tag, " no forward on hit"}, lo_rd_valid, 0);
        @(posedge clk); @(negedge clk);
        req_valid = '0;
        #1;
        chk(hit_valid && hit_id == IW'(id) && hit_data == e, {tag, " hit data"}, hit_data, e);
    endtask

    task automatic load_miss(input int id, input logic [AW-1:0] a, input bit vt, input string tag);
        logic [31:0] e;
        e = word_of(a);
        set_req(id, a, vt, 0);
        #1;
        chk(lo_rd_valid && lo_rd_addr == a && lo_rd_id == IW'(id) && lo_rd_alloc == vt,
            {tag, " forward"}, {lo_rd_valid, lo_rd_alloc, lo_rd_addr}, {1'b1, vt, a});
        @(posedge clk); @(negedge clk);
        req_valid = '0;
        #1;
        chk(hit_valid == 1'b0, {tag, " no hit"}, hit_valid, 0);
        @(posedge clk); @(posedge clk); @(negedge clk);
        #1;
        chk(miss_valid && miss_id == IW'(id) && miss_data == e, {tag, " miss data"}, miss_data, e);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        st_valid = 1'b1; st_addr = a; st_data = d;
        #1;
        chk(lo_wr_valid && lo_wr_addr == a && lo_wr_data == d, {tag, " write-through"}, lo_wr_data, d);
        @(posedge clk);
        mem[a[11:2]] = d;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    int exp_w;
    int best;

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk(!hit_valid && !lo_rd_valid && !miss_valid && req_grant == '0, "R1 idle after reset",
            {hit_valid, lo_rd_valid, miss_valid}, 0);

        // R6 R9 R10: fill every index, then hit every word
        for (int li = 0; li < 8; li++) begin
            load_miss(li % N, AW'(li * 32 + li * 4), 1'b1, "R6 vital miss fill");
            for (int w = 0; w < 8; w++) begin
                @(negedge clk);
                load_hit((li + w) % N, AW'(li * 32 + w * 4), "R10 word select");
            end
            @(negedge clk);
        end

        // R7: non-vital to resident line forwards, never fills
        load_miss(1, 16'h0004, 1'b0, "R7 non-vital resident");
        load_miss(2, 16'h0104, 1'b0, "R7 non-vital other tag");
        load_hit(3, 16'h0004, "R7 line kept");
        @(negedge clk);
        // R9: conflicting tag evicts
        load_miss(0, 16'h0108, 1'b1, "R9 conflict fill");
        load_miss(0, 16'h000c, 1'b1, "R9 evicted line misses");

        // R8: store hit updates, store miss does not allocate
        do_store(16'h0008, 32'hCAFE0001, "R8 store hit");
        load_hit(1, 16'h0008, "R8 updated word");
        @(negedge clk);
        do_store(16'h0208, 32'hBEEF0002, "R8 store miss");
        load_hit(2, 16'h0008, "R8 line kept after store miss");
        @(negedge clk);
        load_miss(2, 16'h0208, 1'b1, "R8 no allocate on store miss");
        load_miss(3, 16'h0008, 1'b1, "R8 refill index 0");

        // R2: store holds off loads, load then retries
        st_valid = 1'b1; st_addr = 16'h0010; st_data = 32'h00112233;
        set_req(1, 16'h0008, 1'b1, 0);
        #1;
        chk(req_grant == '0, "R2 store blocks load", req_grant, 0);
        @(posedge clk);
        mem[16'h0010 >> 2] = 32'h00112233;
        @(negedge clk);
        st_valid = 1'b0;
        #1;
        chk(req_grant == 4'b0010, "R2 load granted after store", req_grant, 2);
        @(posedge clk); @(negedge clk);
        req_valid = '0;
        #1;
        chk(hit_valid && hit_data == word_of(16'h0008), "R2 held load hits", hit_data, word_of(16'h0008));

        // R4: loser retries
        @(negedge clk);
        set_req(0, 16'h0008, 1'b1, 5);
        set_req(2, 16'h0008, 1'b1, 3);
        #1;
        chk(req_grant == 4'b0100, "R4 older wins", req_grant, 4);
        @(posedge clk); @(negedge clk);
        req_valid[2] = 1'b0;
        #1;
        chk(req_grant == 4'b0001, "R4 loser granted next", req_grant, 1);
        @(posedge clk); @(negedge clk);
        req_valid = '0;

        // R3 R4: sweep all valid/vital patterns with three age patterns
        for (int p = 0; p < 3; p++) begin
            for (int v = 1; v < 16; v++) begin
                for (int t = 0; t < 16; t++) begin
                    exp_w = -1;
                    best = 0;
                    for (int i = 0; i < N; i++) begin
                        int key;
                        req_valid[i] = v[i];
                        req_vital[i] = t[i];
                        req_seq[i*SW +: SW] = SW'((i + p) % 3);
                        req_addr[i*AW +: AW] = 16'h0008;
                        key = (t[i] ? 0 : 16) + (i + p) % 3;
                        if (v[i] && (exp_w < 0 || key < best)) begin
                            exp_w = i;
                            best = key;
                        end
                    end
                    #1;
                    chk(req_grant == N'(1 << exp_w), (((v & t) != 0) ? "R3 vital priority" : "R4 age order"),
                        req_grant, 1 << exp_w);
                    @(posedge clk); @(negedge clk);
                end
            end
        end
        req_valid = '0;
        repeat (5) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule